// File: doc/BRIEF.md
# Accumulator and Link Execute Datapath

This block is the execute stage of a small 12-bit accumulator machine. Each cycle it may receive one decoded instruction: a 3-bit opcode, an 8-bit field of operate micro-op bits, and the operand word that memory is delivering on its read bus, with any indirection already resolved upstream. In that single cycle it updates the 12-bit accumulator (AC) and the one-bit link, and it latches the word that must go back into memory. The memory is destructive-read: whatever a memory-referencing instruction reads must be rewritten. The block drives that rewrite on the following cycle from its memory data register.

The operate group lets several micro-ops share one instruction. They run in a fixed chain: clearing comes first, then complementing, then a 13-bit increment of link:AC, then a one- or two-place rotate through the link. Add-with-carry, AND and increment-and-skip-if-zero each finish in one cycle. Increment-and-skip sends the operand through the adder. It replaces the plain rewrite value with the incremented word and raises a skip pulse when that word wraps to zero. Every result is registered and appears on the outputs one clock after the instruction is presented.

Top module: `acc_alu_dp`

## Requirements
- R1: While and directly after synchronous reset, AC, link, the write strobe and the skip output are all 0.
- R2: An operate instruction with the clear-AC bit (ucode bit 0) and the increment bit (bit 4) set leaves AC = 1, whatever AC held before.
- R3: Operate sub-steps run in this order: clear AC (bit 0) and clear link (bit 1), then complement AC (bit 2) and complement link (bit 3), then increment, then rotate. With bits 0, 3, 6 and 7 set and the link initially 0, AC becomes 2 and the link 0. With the link initially 1, AC becomes 0 and the link 0.
- R4: The operate increment works on the 13-bit link:AC pair. With AC = 0xFFF, AC wraps to 0 and the link toggles.
- R5: Rotate-right is bit 5, rotate-left is bit 6, and bit 7 selects two places instead of one. Every rotate runs through the 13-bit link:AC pair. When bits 5 and 6 are both set, no rotate takes place.
- R6: Opcode 1 (add) sets AC to (AC + operand) mod 4096. A carry out of bit 11 complements the link, and otherwise the link keeps its value.
- R7: Opcode 0 (AND) sets AC to the bitwise AND of AC and the operand. The link is unchanged.
- R8: For opcodes 0 and 1, on the cycle after the instruction the write strobe is 1 and the write data equals the operand read. Operate instructions produce no write.
- R9: Opcode 2 (increment-and-skip) writes back (operand + 1) mod 4096 on the next cycle. AC and link are unchanged.
- R10: The skip output is a one-cycle pulse, raised only after an opcode 2 whose operand was 0xFFF.
- R11: Opcode 7 is the operate group. When the instruction-valid input is low, or the opcode is 3 to 6, AC and link are unchanged and neither a write nor a skip occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 3 | Decoded major opcode |
| ucode | input | 8 | Operate-group micro-op bits |
| mem_rd_data | input | 12 | Operand word on the memory read bus |
| ac | output | 12 | Accumulator |
| link | output | 1 | Link bit |
| mem_wr | output | 1 | Rewrite strobe for the memory cycle |
| mem_wr_data | output | 12 | Memory data register contents being rewritten |
| skip | output | 1 | Skip pulse from increment-and-skip |

## Verification
Within one operate instruction, the increment and the rotate can both act on the same carry. When AC is 0xFFF, the increment pushes a carry into the link, and a rotate in the same cycle must then move that new link value into AC. Constrained random operate words set both bits together frequently. Directed cases cover the two documented constant loads, both values of the prior link, and the case where both rotate directions are set. The bench judges each result with a step-by-step model of the micro-op chain, written separately from the design's select-based ALU.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int unsigned WORD_W = 12;
    localparam int unsigned PAIR_W = WORD_W + 1;
    localparam int unsigned OPC_W  = 3;
    localparam int unsigned UC_W   = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PAIR_W-1:0] pair_t;
    typedef logic [OPC_W-1:0]  opc_t;
    typedef logic [UC_W-1:0]   uc_t;

    localparam opc_t OPC_AND = 3'd0;
    localparam opc_t OPC_TAD = 3'd1;
    localparam opc_t OPC_ISZ = 3'd2;
    localparam opc_t OPC_OPR = 3'd7;

    localparam int unsigned UB_CLR_AC = 0;
    localparam int unsigned UB_CLR_LK = 1;
    localparam int unsigned UB_CPL_AC = 2;
    localparam int unsigned UB_CPL_LK = 3;
    localparam int unsigned UB_INC    = 4;
    localparam int unsigned UB_ROT_R  = 5;
    localparam int unsigned UB_ROT_L  = 6;
    localparam int unsigned UB_TWICE  = 7;

    typedef enum logic [1:0] {ASEL_AC, ASEL_ZERO, ASEL_NOT, ASEL_ONES} asel_e;
    typedef enum logic {BSEL_ZERO, BSEL_OPND} bsel_e;
    typedef enum logic {FN_ADD, FN_AND} fn_e;
    typedef enum logic [2:0] {ROT_NONE, ROT_L1, ROT_L2, ROT_R1, ROT_R2} rot_e;
    typedef enum logic {LK_HOLD, LK_ALU} lksel_e;
    typedef enum logic {MDR_BUS, MDR_ALU} mdrsel_e;

    typedef struct packed {
        asel_e   a_sel;
        bsel_e   b_sel;
        logic    cin;
        fn_e     fn;
        logic    lk_clr;
        logic    lk_cpl;
        rot_e    rot;
        logic    ac_we;
        lksel_e  lk_sel;
        mdrsel_e mdr_sel;
        logic    mem_cyc;
        logic    skip_en;
    } ctrl_t;

    function automatic rot_e rot_decode(input logic r, input logic l, input logic two);
        rot_e res;
        unique case ({r, l})
            2'b10:   res = two ? ROT_R2 : ROT_R1;
            2'b01:   res = two ? ROT_L2 : ROT_L1;
            default: res = ROT_NONE;
        endcase
        return res;
    endfunction

    function automatic pair_t rotate_pair(input pair_t v, input rot_e r);
        pair_t res;
        unique case (r)
            ROT_L1:  res = {v[PAIR_W-2:0], v[PAIR_W-1]};
            ROT_L2:  res = {v[PAIR_W-3:0], v[PAIR_W-1:PAIR_W-2]};
            ROT_R1:  res = {v[0], v[PAIR_W-1:1]};
            ROT_R2:  res = {v[1:0], v[PAIR_W-1:2]};
            default: res = v;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
    import acc_alu_pkg::*;
(
    input  logic  valid,
    input  opc_t  opcode,
    input  uc_t   ucode,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl = '0;
        if (valid) begin
            unique case (opcode)
                OPC_AND: begin
                    ctrl.a_sel   = ASEL_AC;
                    ctrl.b_sel   = BSEL_OPND;
                    ctrl.fn      = FN_AND;
                    ctrl.ac_we   = 1'b1;
                    ctrl.mdr_sel = MDR_BUS;
                    ctrl.mem_cyc = 1'b1;
                end
                OPC_TAD: begin
                    ctrl.a_sel   = ASEL_AC;
                    ctrl.b_sel   = BSEL_OPND;
                    ctrl.fn      = FN_ADD;
                    ctrl.ac_we   = 1'b1;
                    ctrl.lk_sel  = LK_ALU;
                    ctrl.mdr_sel = MDR_BUS;
                    ctrl.mem_cyc = 1'b1;
                end
                OPC_ISZ: begin
                    ctrl.a_sel   = ASEL_ZERO;
                    ctrl.b_sel   = BSEL_OPND;
                    ctrl.cin     = 1'b1;
                    ctrl.fn      = FN_ADD;
                    ctrl.mdr_sel = MDR_ALU;
                    ctrl.mem_cyc = 1'b1;
                    ctrl.skip_en = 1'b1;
                end
                OPC_OPR: begin
                    if (ucode[UB_CLR_AC])
                        ctrl.a_sel = ucode[UB_CPL_AC] ? ASEL_ONES : ASEL_ZERO;
                    else
                        ctrl.a_sel = ucode[UB_CPL_AC] ? ASEL_NOT : ASEL_AC;
                    ctrl.b_sel  = BSEL_ZERO;
                    ctrl.cin    = ucode[UB_INC];
                    ctrl.fn     = FN_ADD;
                    ctrl.lk_clr = ucode[UB_CLR_LK];
                    ctrl.lk_cpl = ucode[UB_CPL_LK];
                    ctrl.rot    = rot_decode(ucode[UB_ROT_R], ucode[UB_ROT_L], ucode[UB_TWICE]);
                    ctrl.ac_we  = 1'b1;
                    ctrl.lk_sel = LK_ALU;
                end
                default: ctrl = '0;
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  word_t ac_in,
    input  logic  lk_in,
    input  word_t opnd,
    input  ctrl_t ctrl,
    output word_t ac_out,
    output logic  lk_out
);
    word_t a_w;
    word_t b_w;
    logic  lk_pre;
    pair_t sum_w;
    word_t y_w;
    logic  lk_y;
    pair_t rot_w;

    always_comb begin
        unique case (ctrl.a_sel)
            ASEL_AC:   a_w = ac_in;
            ASEL_ZERO: a_w = '0;
            ASEL_NOT:  a_w = ~ac_in;
            default:   a_w = '1;
        endcase
        b_w    = (ctrl.b_sel == BSEL_OPND) ? opnd : '0;
        lk_pre = (lk_in & ~ctrl.lk_clr) ^ ctrl.lk_cpl;
        sum_w  = {1'b0, a_w} + {1'b0, b_w} + PAIR_W'(ctrl.cin);
        if (ctrl.fn == FN_AND) begin
            y_w  = a_w & b_w;
            lk_y = lk_pre;
        end else begin
            y_w  = sum_w[WORD_W-1:0];
            lk_y = lk_pre ^ sum_w[WORD_W];
        end
        rot_w  = rotate_pair({lk_y, y_w}, ctrl.rot);
        ac_out = rot_w[WORD_W-1:0];
        lk_out = rot_w[WORD_W];
    end
endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
    import acc_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_valid,
    input  logic [2:0]  opcode,
    input  logic [7:0]  ucode,
    input  logic [11:0] mem_rd_data,
    output logic [11:0] ac,
    output logic        link,
    output logic        mem_wr,
    output logic [11:0] mem_wr_data,
    output logic        skip
);
    ctrl_t ctrl;
    word_t ac_q, mdr_q, res_ac;
    logic  lk_q, wr_q, skip_q, res_lk;

    acc_alu_ctrl u_ctrl (
        .valid  (instr_valid),
        .opcode (opcode),
        .ucode  (ucode),
        .ctrl   (ctrl)
    );

    acc_alu_core u_core (
        .ac_in  (ac_q),
        .lk_in  (lk_q),
        .opnd   (mem_rd_data),
        .ctrl   (ctrl),
        .ac_out (res_ac),
        .lk_out (res_lk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q   <= '0;
            lk_q   <= 1'b0;
            mdr_q  <= '0;
            wr_q   <= 1'b0;
            skip_q <= 1'b0;
        end else begin
            if (ctrl.ac_we)
                ac_q <= res_ac;
            if (ctrl.lk_sel == LK_ALU)
                lk_q <= res_lk;
            if (ctrl.mem_cyc)
                mdr_q <= (ctrl.mdr_sel == MDR_ALU) ? res_ac : mem_rd_data;
            wr_q   <= ctrl.mem_cyc;
            skip_q <= ctrl.skip_en && (res_ac == '0);
        end
    end

    assign ac          = ac_q;
    assign link        = lk_q;
    assign mem_wr      = wr_q;
    assign mem_wr_data = mdr_q;
    assign skip        = skip_q;

    assert_tad_sum_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == OPC_TAD) |=>
            (ac == 12'($past(ac) + $past(mem_rd_data))));

    assert_and_link_R7: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == OPC_AND) |=> $stable(link));

    assert_rewrite_R8: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && (opcode == OPC_AND || opcode == OPC_TAD)) |=>
            (mem_wr && mem_wr_data == $past(mem_rd_data)));

    assert_isz_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode == OPC_ISZ) |=> ($stable(ac) && $stable(link) && mem_wr));

    assert_skip_zero_R10: assert property (@(posedge clk) disable iff (rst)
        skip |-> (mem_wr && mem_wr_data == '0));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!instr_valid || !(opcode == OPC_AND || opcode == OPC_TAD ||
                           opcode == OPC_ISZ || opcode == OPC_OPR)) |=>
            ($stable(ac) && $stable(link) && !mem_wr && !skip));

endmodule

// File: tb/acc_alu_dp_tb.sv
`timescale 1ns/1ps
module acc_alu_dp_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [2:0]  opcode;
    logic [7:0]  ucode;
    logic [11:0] mem_rd_data;
    logic [11:0] ac;
    logic        link;
    logic        mem_wr;
    logic [11:0] mem_wr_data;
    logic        skip;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [11:0] m_ac;
    logic        m_lk;

    always #2 clk = ~clk;

    acc_alu_dp dut_i (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .opcode      (opcode),
        .ucode       (ucode),
        .mem_rd_data (mem_rd_data),
        .ac          (ac),
        .link        (link),
        .mem_wr      (mem_wr),
        .mem_wr_data (mem_wr_data),
        .skip        (skip)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [12:0] model_opr(input logic [11:0] a_in, input logic l_in,
                                              input logic [7:0] uc);
        logic [11:0] a = a_in;
        logic        l = l_in;
        logic [12:0] p;
        if (uc[0]) a = 12'h000;
        if (uc[1]) l = 1'b0;
        if (uc[2]) a = ~a;
        if (uc[3]) l = ~l;
        p = {l, a};
        if (uc[4]) p = p + 13'd1;
        if (uc[5] ^ uc[6]) begin
            for (int k = 0; k < (uc[7] ? 2 : 1); k++) begin
                if (uc[6]) p = {p[11:0], p[12]};
                else       p = {p[0], p[12:1]};
            end
        end
        return p;
    endfunction

    task automatic exec(input logic v, input logic [2:0] op, input logic [7:0] uc,
                        input logic [11:0] d, input string req);
        logic        e_wr = 1'b0;
        logic [11:0] e_wd = 12'h000;
        logic        e_sk = 1'b0;
        logic [12:0] t;
        string       wtag = "R11";
        if (v) begin
            case (op)
                3'd0: begin m_ac = m_ac & d; e_wr = 1'b1; e_wd = d; wtag = "R8"; end
                3'd1: begin
                    t = {1'b0, m_ac} + {1'b0, d};
                    m_ac = t[11:0];
                    m_lk = m_lk ^ t[12];
                    e_wr = 1'b1; e_wd = d; wtag = "R8";
                end
                3'd2: begin e_wr = 1'b1; e_wd = d + 12'd1; e_sk = (d == 12'hFFF); wtag = "R9"; end
                3'd7: begin t = model_opr(m_ac, m_lk, uc); m_ac = t[11:0]; m_lk = t[12]; wtag = "R8"; end
                default: ;
            endcase
        end
        instr_valid = v;
        opcode      = op;
        ucode       = uc;
        mem_rd_data = d;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(req, "ac", int'(ac), int'(m_ac));
        chk(req, "link", int'(link), int'(m_lk));
        chk(wtag, "mem_wr", int'(mem_wr), int'(e_wr));
        if (e_wr) chk(wtag, "mem_wr_data", int'(mem_wr_data), int'(e_wd));
        chk((v && op == 3'd2) ? "R10" : "R11", "skip", int'(skip), int'(e_sk));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; instr_valid = 1'b0; opcode = 3'd0; ucode = 8'h00; mem_rd_data = 12'h000;
        m_ac = 12'h000; m_lk = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", "ac in reset", int'(ac), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ac", int'(ac), 0);
        chk("R1", "link", int'(link), 0);
        chk("R1", "mem_wr", int'(mem_wr), 0);
        chk("R1", "skip", int'(skip), 0);

        exec(1, 3'd1, 8'h00, 12'h5A5, "R6");
        exec(1, 3'd7, 8'h11, 12'h000, "R2");
        exec(1, 3'd7, 8'h02, 12'h000, "R3");
        exec(1, 3'd7, 8'hC9, 12'h000, "R3");
        exec(1, 3'd7, 8'h0A, 12'h000, "R3");
        exec(1, 3'd7, 8'hC9, 12'h000, "R3");
        exec(1, 3'd7, 8'h03, 12'h000, "R3");
        exec(1, 3'd1, 8'h00, 12'hFFF, "R6");
        exec(1, 3'd7, 8'h10, 12'h000, "R4");
        exec(1, 3'd7, 8'h07, 12'h000, "R4");
        exec(1, 3'd7, 8'hD0, 12'h000, "R4");
        exec(1, 3'd7, 8'h03, 12'h000, "R5");
        exec(1, 3'd1, 8'h00, 12'h801, "R6");
        exec(1, 3'd7, 8'h20, 12'h000, "R5");
        exec(1, 3'd7, 8'h40, 12'h000, "R5");
        exec(1, 3'd7, 8'hA0, 12'h000, "R5");
        exec(1, 3'd7, 8'hC0, 12'h000, "R5");
        exec(1, 3'd7, 8'h60, 12'h000, "R5");
        exec(1, 3'd7, 8'hE0, 12'h000, "R5");
        exec(1, 3'd7, 8'h03, 12'h000, "R6");
        exec(1, 3'd1, 8'h00, 12'h800, "R6");
        exec(1, 3'd1, 8'h00, 12'h800, "R6");
        exec(1, 3'd1, 8'h00, 12'h7FF, "R6");
        exec(1, 3'd1, 8'h00, 12'h001, "R6");
        exec(1, 3'd0, 8'h00, 12'h0F0, "R7");
        exec(1, 3'd2, 8'h00, 12'hFFF, "R10");
        exec(1, 3'd2, 8'h00, 12'h000, "R9");
        exec(1, 3'd2, 8'h00, 12'h7FF, "R9");
        exec(1, 3'd4, 8'hFF, 12'hFFF, "R11");
        exec(1, 3'd5, 8'h11, 12'h123, "R11");
        exec(0, 3'd2, 8'h00, 12'hFFF, "R11");
        exec(0, 3'd7, 8'h03, 12'h000, "R11");

        void'($urandom(32'd20240611));
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  op = 3'($urandom % 8);
            logic        v  = (($urandom % 8) != 0);
            logic [7:0]  uc = 8'($urandom);
            logic [11:0] d  = 12'($urandom);
            string       tag;
            if ((i % 16) == 0) d = 12'hFFF;
            if (!v)              tag = "R11";
            else if (op == 3'd0) tag = "R7";
            else if (op == 3'd1) tag = "R6";
            else if (op == 3'd2) tag = "R9";
            else if (op == 3'd7) tag = "R3";
            else                 tag = "R11";
            exec(v, op, uc, d, tag);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule